// File: doc/BRIEF.md
# Up-Counting Compare Timer with Reset/Set PWM

This block is a timer with a fixed period. Its counter climbs from zero to a programmed period value and then returns to zero, so each cycle lasts period + 1 clock ticks. The period register acts as compare channel 0. A set of general compare channels (two by default) sit beside it. Each general channel raises a flag when the counter reaches its value and drives a PWM output. That output is set high when the counter reaches the period and pulled low when it reaches the channel's own compare value.

The channel-0 match flag has its own service path and is cleared by an acknowledge pulse. The general-channel flags and the wrap flag leave the block as a raw vector. A separate interrupt vector encoder takes them from there, and software clears them through a write-one-to-clear register. Every flag has an enable bit, and each masked request is brought out next to the raw flag.

All programming goes through a single-cycle write port. A register write takes effect at the clock edge on which it is presented.

Top module: `upcmp_timer`

## Requirements
- R1: While running, the counter steps by one on each tick. On the tick after it holds a value equal to or above the period it returns to zero, so the cycle length is period + 1 ticks.
- R2: The channel-0 flag (`p_flag`) sets on the tick at which the counter becomes equal to the period. The wrap flag (`raw_flags[NCMP]`) sets one tick later, on the tick at which the counter goes back to zero.
- R3: General channel i (flag bit i-1) sets its flag on the tick at which the counter becomes equal to its compare value. A general-channel match never sets `p_flag`.
- R4: A one-cycle `p_ack` clears `p_flag` and leaves every bit of `raw_flags` unchanged.
- R5: Control register bit 2 enables channel 0, and bits 3 to 3+NCMP enable the flags in `raw_flags` order. `p_irq` is `p_flag` AND its enable. `raw_irq` is `raw_flags` AND their enables.
- R6: With control bit 0 (run) at zero, the counter holds its value and no flag sets.
- R7: Writing control register address 0 with bit 1 set forces the counter to zero on that edge. This takes priority over counting.
- R8: With a period of zero, the counter stays at zero and no flag sets, even with run at one.
- R9: For each general channel, the PWM output goes high on the tick the counter reaches the period and goes low on the tick it reaches the channel compare value. Set wins when both happen on the same tick. For 0 <= compare < period the output is high for compare + 1 ticks of each cycle. For compare >= period it stays high.
- R10: Writing address NCMP+2 clears each `raw_flags` bit whose data bit is one. A flag set on the same edge stays set.
- R11: After reset, the counter, all flags, all requests and all PWM outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address: 0 control, 1 period, 2..NCMP+1 compares, NCMP+2 flag clear |
| wr_data | input | CW | Write data |
| p_ack | input | 1 | Channel-0 service acknowledge, clears `p_flag` |
| cnt | output | CW | Counter value |
| p_flag | output | 1 | Channel-0 (period) match flag |
| p_irq | output | 1 | Channel-0 request (flag AND enable) |
| raw_flags | output | NCMP+1 | General-channel flags in bits 0..NCMP-1, wrap flag in bit NCMP |
| raw_irq | output | NCMP+1 | `raw_flags` AND their enables |
| pwm | output | NCMP | Reset/set PWM output per general channel |

## Verification
Two cases are the hardest to reach from the ports, because they depend on exactly where the running counter is when a write lands. One is a flag clear that arrives on the same edge as a new match of that flag. The other is a period rewrite that leaves the counter above the new period. The stimulus first uses the run/clear control write to lock the counter to a known phase. It then polls `cnt` at the falling edge until it reaches the value one tick before the target, and only then issues the write. Duty is measured by counting PWM high samples across one full cycle, which starts after a complete wrap so that the output's earlier state drops out.

// File: rtl/upcmp_timer.sv
module upcmp_timer #(
  parameter int CW   = 16,
  parameter int NCMP = 2,
  parameter int AW   = $clog2(NCMP + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            p_ack,
  output logic [CW-1:0]   cnt,
  output logic            p_flag,
  output logic            p_irq,
  output logic [NCMP:0]   raw_flags,
  output logic [NCMP:0]   raw_irq,
  output logic [NCMP-1:0] pwm
);

  localparam int FW = NCMP + 1;
  localparam logic [AW-1:0] A_CTRL = '0;
  localparam logic [AW-1:0] A_PER  = AW'(1);
  localparam logic [AW-1:0] A_FCLR = AW'(NCMP + 2);

  logic          run_q, iep_q;
  logic [FW-1:0] ie_q;
  logic [CW-1:0] per_q;
  logic [CW-1:0] cmp_q [NCMP];
  logic [CW-1:0] cnt_q, nxt;
  logic          pf_q;
  logic [FW-1:0] fl_q;
  logic [NCMP-1:0] pwm_q, hit_c;

  wire clr_now  = wr_en && wr_addr == A_CTRL && wr_data[1];
  wire active   = run_q && per_q != '0 && !clr_now;
  wire wrap_now = cnt_q >= per_q;
  wire hit_p    = active && nxt == per_q;
  wire [FW-1:0] fset = {active && wrap_now, hit_c};
  wire [FW-1:0] fclr = (wr_en && wr_addr == A_FCLR) ? wr_data[FW-1:0] : '0;

  assign nxt = wrap_now ? '0 : cnt_q + CW'(1);

  always_comb
    for (int i = 0; i < NCMP; i++) hit_c[i] = active && nxt == cmp_q[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0;
      iep_q <= 1'b0;
      ie_q  <= '0;
      per_q <= '0;
      for (int i = 0; i < NCMP; i++) cmp_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        run_q <= wr_data[0];
        iep_q <= wr_data[2];
        ie_q  <= wr_data[3 +: FW];
      end
      if (wr_addr == A_PER) per_q <= wr_data;
      for (int i = 0; i < NCMP; i++)
        if (wr_addr == AW'(i + 2)) cmp_q[i] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      pf_q  <= 1'b0;
      fl_q  <= '0;
      pwm_q <= '0;
    end else begin
      if (clr_now)    cnt_q <= '0;
      else if (run_q) cnt_q <= nxt;
      pf_q <= (pf_q & ~p_ack) | hit_p;
      fl_q <= (fl_q & ~fclr) | fset;
      for (int i = 0; i < NCMP; i++)
        if (hit_p)         pwm_q[i] <= 1'b1;
        else if (hit_c[i]) pwm_q[i] <= 1'b0;
    end

  assign cnt       = cnt_q;
  assign p_flag    = pf_q;
  assign p_irq     = pf_q & iep_q;
  assign raw_flags = fl_q;
  assign raw_irq   = fl_q & ie_q;
  assign pwm       = pwm_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !clr_now && cnt_q < per_q) |=> cnt_q == $past(cnt_q) + CW'(1)); // R1
  AST_WRAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q == per_q) |=> (cnt == '0 && raw_flags[NCMP])); // R2
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_now) |=> $stable(cnt)); // R6
  AST_STOP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> ((raw_flags & ~$past(raw_flags)) == '0 && !(p_flag && !$past(p_flag)))); // R6
  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && run_q && !clr_now) |=> (cnt == '0 && !(raw_flags[NCMP] && !$past(raw_flags[NCMP])))); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> cnt == '0); // R7
  AST_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_p |=> &pwm); // R9

endmodule

// File: tb/sim_upcmp_timer.sv
module sim_upcmp_timer;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, p_ack = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic p_flag, p_irq;
  logic [2:0] raw_flags, raw_irq;
  logic [1:0] pwm;
  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [15:0] held;

  always #10 clk = ~clk;

  upcmp_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .p_ack(p_ack), .cnt(cnt), .p_flag(p_flag), .p_irq(p_irq),
    .raw_flags(raw_flags), .raw_irq(raw_irq), .pwm(pwm));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(logic [15:0] v);
    for (int i = 0; i < 100 && cnt != v; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 cnt", cnt, 0);
    chk("R11 flags", {p_flag, raw_flags, p_irq, raw_irq, pwm}, 0);
  endtask

  task automatic t_count;
    wr(1, 4); wr(2, 2); wr(3, 4);
    chk("R6 idle cnt", cnt, 0);
    wr(0, 16'd35);
    chk("R7 start", cnt, 0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R1 seq", cnt, k % 5);
      if (k == 2) chk("R3 ch1 only", {p_flag, raw_flags[0]}, 2'b01);
      if (k == 4) begin
        chk("R2 p_flag", {p_flag, raw_flags[2]}, 2'b10);
        chk("R9 set", pwm, 2'b11);
      end
      if (k == 5) begin
        chk("R2 wrap", raw_flags, 3'b111);
        chk("R5 masks", {p_irq, raw_irq}, 4'b0100);
      end
      if (k == 6) chk("R9 high", pwm, 2'b11);
      if (k == 7) chk("R9 reset", pwm, 2'b10);
    end
  endtask

  task automatic t_ack;
    p_ack = 1'b1;
    @(negedge clk);
    p_ack = 1'b0;
    chk("R4 ack", {p_flag, raw_flags}, 4'b0111);
  endtask

  task automatic t_fclr;
    wait_cnt(2);
    wr(4, 3'b101);
    chk("R10 clear", raw_flags, 3'b010);
    wait_cnt(1);
    wr(4, 3'b001);
    chk("R10 set wins", raw_flags[0], 1'b1);
  endtask

  task automatic t_irq;
    wr(0, 16'd13);
    chk("R5 enables", {p_irq, raw_irq}, {p_flag, 2'b00, raw_flags[0]});
    chk("R5 p_irq", p_irq, 1'b1);
  endtask

  task automatic t_stop;
    wait_cnt(2);
    wr(0, 0);
    held = cnt;
    chk("R6 last step", held, 3);
    p_ack = 1'b1;
    wr(4, 3'b111);
    p_ack = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 hold", cnt, held);
    chk("R6 no flags", {p_flag, raw_flags}, 0);
    wr(0, 2);
    chk("R7 clear", cnt, 0);
    repeat (3) @(negedge clk);
    chk("R7 stays", cnt, 0);
    wr(0, 1);
    repeat (3) @(negedge clk);
    wr(0, 3);
    chk("R7 priority", cnt, 0);
  endtask

  task automatic t_zero;
    wr(1, 0);
    p_ack = 1'b1;
    wr(4, 3'b111);
    p_ack = 1'b0;
    @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R8 cnt", cnt, 0);
    chk("R8 flags", {p_flag, raw_flags}, 0);
  endtask

  task automatic t_duty;
    int hi1 = 0, hi2 = 0, len = 0;
    wr(1, 9); wr(2, 3); wr(3, 12); wr(0, 3);
    wait_cnt(9);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      hi1 += int'(pwm[0]);
      hi2 += int'(pwm[1]);
      @(negedge clk);
      len++;
      if (cnt == 0) break;
    end
    chk("R1 length", len, 10);
    chk("R9 duty ch1", hi1, 4);
    chk("R9 ch2 high", hi2, 10);
    wait_cnt(8);
    wr(1, 5);
    chk("R1 old period", cnt, 9);
    @(negedge clk);
    chk("R1 beyond wraps", cnt, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_ack();
    t_fclr();
    t_irq();
    t_stop();
    t_zero();
    t_duty();
    finish_run();
  end

  initial begin
    #4000000;
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule